// File: doc/BRIEF.md
# Packed-Halfword Instruction Fetch and Address Sequencer

This block is the front end of a small word-addressed processor whose 16-bit instructions are stored two to a 32-bit word. It keeps a word program counter together with a one-bit halfword selector. It reads instruction words from a synchronous memory port and picks the active halfword. For memory-reference instructions it forms the operand address, with at most one indirect read. It then hands the instruction to an execute stage over a valid/ready handshake.

The upper halfword (bits 31:16) runs first and the lower halfword (bits 15:0) runs second. Moving from the upper to the lower halfword reuses the word already held and issues no new read. Jumps and subroutine calls are resolved here. Both always resume in the upper halfword of a word. I/O and operate instructions get no address processing and are only flagged by class.

Back-pressure rules on the execute side: `ex_valid` stays high until a cycle with `ex_ready` high. All `ex_*` outputs hold still while the offer is pending. Nothing advances (program counter, selector or memory traffic) until that accepting cycle. `ex_ready` may be held high permanently. The memory port has a fixed latency of one cycle: data for a read issued in cycle N is sampled in cycle N+1. A write takes effect at the edge that ends its cycle.

Top module: `fetch_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ex_valid` is 0. The first cycle after reset issues a read of word `RESET_PC` (default 0), and the first instruction offered has `ex_half` = 0.
- R2: The upper halfword is offered with `ex_half` = 0, and the lower halfword of the same word follows with `ex_half` = 1 and the same `ex_pc`, with no memory read between them. After the lower halfword the next word (`ex_pc`+1) is fetched.
- R3: Instruction bit 15 is the indirect flag and bits 14:12 are the operation. Operation 6 is flagged I/O and operation 7 is flagged operate, whatever bit 15 holds. Such instructions cause no operand read and present `ex_addr` = 0. Exactly one class flag is high while `ex_valid` is high.
- R4: For operations 0 to 5 with bit 15 clear, `ex_addr` = {`ex_pc`[31:11], instruction[10:0]}. Instruction bit 11 has no effect on any address.
- R5: For operations 0 to 5 with bit 15 set, exactly one extra read is made at the direct address of R4. The full 32-bit word returned becomes `ex_addr`, and it is never followed further.
- R6: Operation 5 (jump): after acceptance the next read is at `ex_addr`, and the next instruction offered is the upper halfword of that word.
- R7: Operation 4 (call): in the accepting cycle, the value `ex_pc`+1 is written to word `ex_addr`. The next read is at `ex_addr`+1, and execution continues from its upper halfword.
- R8: While `ex_valid` is high and `ex_ready` is low, all `ex_*` outputs are stable and no write is issued.
- R9: Read and write are never issued in the same cycle. A write occurs only in a cycle in which a call is accepted.
- R10: A sequential step from the lower halfword of word 0x7FF moves to word 0x800. Direct addresses formed there take the new page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data (return word address) |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| ex_valid | output | 1 | Instruction offered to execute stage |
| ex_ready | input | 1 | Execute stage accepts the offer |
| ex_instr | output | 16 | Selected 16-bit instruction |
| ex_op | output | 3 | Operation field (instruction bits 14:12) |
| ex_ind | output | 1 | Indirect flag (instruction bit 15) |
| ex_addr | output | 32 | Final operand address, 0 for I/O and operate |
| ex_is_mem | output | 1 | Memory-reference class |
| ex_is_io | output | 1 | I/O class |
| ex_is_opr | output | 1 | Operate class |
| ex_pc | output | 32 | Word address of the offered instruction |
| ex_half | output | 1 | Halfword of the offered instruction (0 upper, 1 lower) |

## Verification
Two functions share the accepting cycle of a call: the memory write of the return address, and the redirection of the program counter to the word after the target. The bench offers a call and holds `ex_ready` low for several cycles. During those cycles it confirms that no write appears and that the offer stays frozen. It then accepts the call and checks three things: the written word in its memory model, that the next fetch is the target plus one, and the upper halfword. The sequential halfword toggle and the indirect operand read also meet in one step, when an indirect instruction sits in the lower halfword. For that step the bench counts memory reads between offers and expects exactly one.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_WAIT,
    ST_DEC,
    ST_IWAIT,
    ST_OUT
  } fseq_state_e;

  localparam logic [2:0] OP_CALL = 3'd4;
  localparam logic [2:0] OP_JUMP = 3'd5;
  localparam logic [2:0] OP_IO   = 3'd6;
  localparam logic [2:0] OP_OPR  = 3'd7;

  typedef struct packed {
    logic is_mem;
    logic is_io;
    logic is_opr;
  } iclass_t;

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int INSTR_W = 16,
  parameter int OFFS_W  = 11,
  localparam int PAGE_W = WORD_W - OFFS_W
) (
  input  logic [WORD_W-1:0]  word,
  input  logic               half_sel,
  input  logic [PAGE_W-1:0]  pc_page,
  output logic [INSTR_W-1:0] instr,
  output logic [2:0]         op,
  output logic               ind,
  output iclass_t            cls,
  output logic [WORD_W-1:0]  ea_direct
);

  localparam int SLOTS = WORD_W / INSTR_W;

  logic [INSTR_W-1:0] slot [SLOTS];

  // slot 0 is the upper halfword, executed first
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot[g] = word[WORD_W-1-g*INSTR_W -: INSTR_W];
  end

  always_comb begin
    instr = slot[half_sel];
    ind   = instr[INSTR_W-1];
    op    = instr[INSTR_W-2 -: 3];
    cls.is_io  = (op == OP_IO);
    cls.is_opr = (op == OP_OPR);
    cls.is_mem = !(cls.is_io || cls.is_opr);
    ea_direct  = {pc_page, instr[OFFS_W-1:0]};
  end

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
  parameter int          WORD_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              redirect,
  input  logic [WORD_W-1:0] target,
  output logic [WORD_W-1:0] pc,
  output logic              hsel
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= RESET_PC[WORD_W-1:0];
      hsel <= 1'b0;
    end else if (adv) begin
      if (redirect) begin
        pc   <= target;
        hsel <= 1'b0;
      end else if (!hsel) begin
        hsel <= 1'b1;
      end else begin
        hsel <= 1'b0;
        pc   <= pc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  pc,
  input  logic               hsel,
  input  logic [INSTR_W-1:0] dec_instr,
  input  logic [2:0]         dec_op,
  input  logic               dec_ind,
  input  iclass_t            dec_cls,
  input  logic [WORD_W-1:0]  dec_ea,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic               ex_ready,
  output logic [WORD_W-1:0]  word_q,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               ex_valid,
  output logic [INSTR_W-1:0] ex_instr,
  output logic [2:0]         ex_op,
  output logic               ex_ind,
  output iclass_t            ex_cls,
  output logic [WORD_W-1:0]  ex_addr,
  output logic               adv,
  output logic               redirect,
  output logic [WORD_W-1:0]  target
);

  fseq_state_e state, state_nx;
  logic        is_call, is_jump, need_ind;

  assign ex_valid = (state == ST_OUT);
  assign adv      = ex_valid && ex_ready;
  assign is_call  = ex_cls.is_mem && (ex_op == OP_CALL);
  assign is_jump  = ex_cls.is_mem && (ex_op == OP_JUMP);
  assign redirect = is_call || is_jump;
  assign target   = is_call ? ex_addr + 1'b1 : ex_addr;
  assign need_ind = dec_cls.is_mem && dec_ind;

  always_comb begin
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_addr  = pc;
    mem_wdata = pc + 1'b1;
    unique case (state)
      ST_FETCH: mem_rd_en = 1'b1;
      ST_DEC: begin
        mem_rd_en = need_ind;
        mem_addr  = dec_ea;
      end
      ST_OUT: begin
        mem_wr_en = adv && is_call;
        mem_addr  = ex_addr;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_FETCH: state_nx = ST_WAIT;
      ST_WAIT:  state_nx = ST_DEC;
      ST_DEC:   state_nx = need_ind ? ST_IWAIT : ST_OUT;
      ST_IWAIT: state_nx = ST_OUT;
      ST_OUT: begin
        if (adv) state_nx = (redirect || hsel) ? ST_FETCH : ST_DEC;
      end
      default:  state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_FETCH;
      word_q   <= '0;
      ex_instr <= '0;
      ex_op    <= '0;
      ex_ind   <= 1'b0;
      ex_cls   <= '0;
      ex_addr  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_WAIT) word_q <= mem_rdata;
      if (state == ST_DEC) begin
        ex_instr <= dec_instr;
        ex_op    <= dec_op;
        ex_ind   <= dec_ind;
        ex_cls   <= dec_cls;
        ex_addr  <= dec_cls.is_mem ? dec_ea : '0;
      end
      if (state == ST_IWAIT) ex_addr <= mem_rdata;
    end
  end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fseq_pkg::*;
#(
  parameter int          WORD_W   = 32,
  parameter int          INSTR_W  = 16,
  parameter int          OFFS_W   = 11,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               ex_valid,
  input  logic               ex_ready,
  output logic [INSTR_W-1:0] ex_instr,
  output logic [2:0]         ex_op,
  output logic               ex_ind,
  output logic [WORD_W-1:0]  ex_addr,
  output logic               ex_is_mem,
  output logic               ex_is_io,
  output logic               ex_is_opr,
  output logic [WORD_W-1:0]  ex_pc,
  output logic               ex_half
);

  localparam int PAGE_W = WORD_W - OFFS_W;

  logic [WORD_W-1:0]  pc, word_q, dec_ea, target;
  logic               hsel, adv, redirect, dec_ind;
  logic [INSTR_W-1:0] dec_instr;
  logic [2:0]         dec_op;
  iclass_t            dec_cls, ex_cls;

  fseq_pc #(.WORD_W(WORD_W), .RESET_PC(RESET_PC)) pc_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .redirect(redirect),
    .target(target), .pc(pc), .hsel(hsel)
  );

  fseq_decode #(.WORD_W(WORD_W), .INSTR_W(INSTR_W), .OFFS_W(OFFS_W)) dec_i (
    .word(word_q), .half_sel(hsel), .pc_page(pc[WORD_W-1 -: PAGE_W]),
    .instr(dec_instr), .op(dec_op), .ind(dec_ind), .cls(dec_cls),
    .ea_direct(dec_ea)
  );

  fseq_ctrl #(.WORD_W(WORD_W), .INSTR_W(INSTR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .pc(pc), .hsel(hsel),
    .dec_instr(dec_instr), .dec_op(dec_op), .dec_ind(dec_ind),
    .dec_cls(dec_cls), .dec_ea(dec_ea), .mem_rdata(mem_rdata),
    .ex_ready(ex_ready), .word_q(word_q), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_op(ex_op),
    .ex_ind(ex_ind), .ex_cls(ex_cls), .ex_addr(ex_addr), .adv(adv),
    .redirect(redirect), .target(target)
  );

  assign ex_is_mem = ex_cls.is_mem;
  assign ex_is_io  = ex_cls.is_io;
  assign ex_is_opr = ex_cls.is_opr;
  assign ex_pc     = pc;
  assign ex_half   = hsel;

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int WORD_W  = 32,
  parameter int INSTR_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_rd_en,
  input logic               mem_wr_en,
  input logic [WORD_W-1:0]  mem_addr,
  input logic [WORD_W-1:0]  mem_wdata,
  input logic               ex_valid,
  input logic               ex_ready,
  input logic [INSTR_W-1:0] ex_instr,
  input logic [2:0]         ex_op,
  input logic [WORD_W-1:0]  ex_addr,
  input logic               ex_is_mem,
  input logic               ex_is_io,
  input logic               ex_is_opr,
  input logic [WORD_W-1:0]  ex_pc,
  input logic               ex_half
);

  logic acc, acc_jump, acc_call, acc_seq;
  assign acc      = ex_valid && ex_ready;
  assign acc_jump = acc && ex_is_mem && (ex_op == 3'd5);
  assign acc_call = acc && ex_is_mem && (ex_op == 3'd4);
  assign acc_seq  = acc && !acc_jump && !acc_call;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_ready |=> ex_valid && $stable(ex_addr) && $stable(ex_instr)
      && $stable(ex_pc) && $stable(ex_half));

  assert_no_wr_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_ready |-> !mem_wr_en);

  assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_wr_on_call_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> acc_call);

  assert_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> $onehot({ex_is_mem, ex_is_io, ex_is_opr}));

  assert_noaddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && (ex_is_io || ex_is_opr) |-> ex_addr == '0);

  assert_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_jump |=> mem_rd_en && mem_addr == $past(ex_addr) && !ex_half);

  assert_call_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_call |-> mem_wr_en && mem_addr == ex_addr && mem_wdata == ex_pc + 1);

  assert_call_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_call |=> mem_rd_en && mem_addr == $past(ex_addr) + 1 && !ex_half);

  assert_upper_to_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_seq && !ex_half |=> ex_half && ex_pc == $past(ex_pc));

  assert_lower_to_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_seq && ex_half |=> !ex_half && ex_pc == $past(ex_pc) + 1);

endmodule

bind fetch_seq fseq_checker #(.WORD_W(WORD_W), .INSTR_W(INSTR_W)) chk_i (.*);

// File: tb/fetch_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        ex_valid, ex_ready, ex_ind, ex_is_mem, ex_is_io, ex_is_opr, ex_half;
  logic [15:0] ex_instr;
  logic [2:0]  ex_op;
  logic [31:0] ex_addr, ex_pc;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int rd_mark = 0;
  int cyc = 0;

  logic [31:0] mem [4096];

  always #4 clk = ~clk;

  fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_instr(ex_instr),
    .ex_op(ex_op), .ex_ind(ex_ind), .ex_addr(ex_addr), .ex_is_mem(ex_is_mem),
    .ex_is_io(ex_is_io), .ex_is_opr(ex_is_opr), .ex_pc(ex_pc), .ex_half(ex_half)
  );

  // one-cycle synchronous memory model
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
    if (rst_n && mem_rd_en) rd_cnt <= rd_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // waits for an offer, checks it, optionally stalls, then accepts it
  task automatic take(input logic [31:0] epc, input bit ehalf, input logic [15:0] einstr,
                      input logic [31:0] eaddr, input logic [2:0] ecls,
                      input int ereads, input int hold, input string tag);
    logic [31:0] a0;
    while (!ex_valid) @(negedge clk);
    chk(ex_pc == epc,       {tag, " pc"},    ex_pc, epc);
    chk(ex_half == ehalf,   {tag, " half"},  {31'd0, ex_half}, {31'd0, ehalf});
    chk(ex_instr == einstr, {tag, " instr"}, {16'd0, ex_instr}, {16'd0, einstr});
    chk(ex_addr == eaddr,   {tag, " addr"},  ex_addr, eaddr);
    chk({ex_is_mem, ex_is_io, ex_is_opr} == ecls, {tag, " class"},
        {29'd0, ex_is_mem, ex_is_io, ex_is_opr}, {29'd0, ecls});
    chk(rd_cnt - rd_mark == ereads, {tag, " reads"}, rd_cnt - rd_mark, ereads);
    a0 = ex_addr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(ex_valid && ex_addr == a0 && !mem_wr_en, "R8 stall hold", ex_addr, a0);
    end
    ex_ready = 1'b1;
    @(negedge clk);
    ex_ready = 1'b0;
    rd_mark = rd_cnt;
  endtask

  task automatic t_reset;
    ex_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ex_valid, "R1 valid in reset", {31'd0, ex_valid}, 32'd0);
    rst_n = 1'b1;
    chk(!ex_valid, "R1 valid after reset", {31'd0, ex_valid}, 32'd0);
    chk(mem_rd_en && mem_addr == 32'h0, "R1 first read", mem_addr, 32'h0);
  endtask

  task automatic t_pairing;
    // R4 bit 11 ignored, R2 upper first
    take(32'h0, 1'b0, 16'h1805, 32'h5, 3'b100, 1, 0, "R4 direct");
    // R5 indirect in lower half: exactly one read, no refetch (R2)
    take(32'h0, 1'b1, 16'h9806, 32'hDEAD0123, 3'b100, 1, 0, "R5 indirect");
    // R3 io then operate with bit 15 set
    take(32'h1, 1'b0, 16'h6034, 32'h0, 3'b010, 1, 0, "R3 io");
    take(32'h1, 1'b1, 16'hF300, 32'h0, 3'b001, 0, 0, "R3 opr");
  endtask

  task automatic t_jump_call;
    take(32'h2, 1'b0, 16'h5020, 32'h20, 3'b100, 1, 0, "R6 jump");
    take(32'h20, 1'b0, 16'h7000, 32'h0, 3'b001, 1, 0, "R6 target upper");
    // R7 call held under back-pressure
    take(32'h20, 1'b1, 16'h4030, 32'h30, 3'b100, 0, 3, "R7 call");
    chk(mem[12'h030] == 32'h21, "R7 return word", mem[12'h030], 32'h21);
    take(32'h31, 1'b0, 16'hD040, 32'h7FF, 3'b100, 2, 0, "R7 resume");
  endtask

  task automatic t_page;
    take(32'h7FF, 1'b0, 16'h7000, 32'h0, 3'b001, 1, 0, "R6 indirect jump");
    take(32'h7FF, 1'b1, 16'h0123, 32'h123, 3'b100, 0, 0, "R10 old page");
    take(32'h800, 1'b0, 16'h0123, 32'h923, 3'b100, 1, 0, "R10 new page");
    take(32'h800, 1'b1, 16'h5000, 32'h800, 3'b100, 0, 0, "R10 jump");
    take(32'h800, 1'b0, 16'h0123, 32'h923, 3'b100, 1, 0, "R6 loop");
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h7000_7000;
    mem[12'h000] = 32'h1805_9806;
    mem[12'h001] = 32'h6034_F300;
    mem[12'h002] = 32'h5020_7000;
    mem[12'h006] = 32'hDEAD_0123;
    mem[12'h020] = 32'h7000_4030;
    mem[12'h030] = 32'h0;
    mem[12'h031] = 32'hD040_7000;
    mem[12'h040] = 32'h0000_07FF;
    mem[12'h7FF] = 32'h7000_0123;
    mem[12'h800] = 32'h0123_5000;
    ex_ready = 1'b0;
    @(negedge clk);
    t_reset();
    t_pairing();
    t_jump_call();
    t_page();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule